// File: doc/BRIEF.md
# Sixteen-Bit Bus Address and Byte-Lane Generator

This block sits between a core's transfer logic and the pins of a 16-bit external data bus. Each request it takes in carries a 24-bit byte address, a size (byte or word), a direction and a cycle kind. The cycle kind is one of four: memory, programmed I/O, coprocessor command or coprocessor data. From each request the block produces the word address lines (bits 23 to 1), two active-low byte-lane enables and a drive enable for the data pins. Byte address bit 0 never reaches the pins. For a byte transfer it only picks the lane.

The block runs on a double-rate input clock. It counts each period of that clock as one phase of the internal clock, so phase one and phase two alternate. Releasing reset always puts the counter into a known phase. A request is sampled only at the edge that opens phase one, and the registered outputs then hold for the whole internal clock. While a bus hold is acknowledged, the pad drive enables drop so that the address, lane and data pins float.

Top module: `bus_lane_gen`

## Requirements
- R1: `phase2_o` inverts on every `clk2` edge out of reset. While reset is low it reads 1. The first edge after reset is released therefore opens phase one (`phase2_o` = 0).
- R2: The address, lane enables, `cyc_active_o` and `req_err_o` change only at an edge that opens phase one. They are held unchanged at the edge that opens phase two.
- R3: The lane enables are active low. A word transfer drives both `ube_n_o` and `lbe_n_o` to 0.
- R4: For a byte transfer, byte address bit 0 = 0 gives `lbe_n_o`=0 and `ube_n_o`=1. Bit 0 = 1 gives `ube_n_o`=0 and `lbe_n_o`=1.
- R5: While `cyc_active_o` is 1, the two enables are never both 1. When no cycle is active, both read 1.
- R6: A memory cycle (`req_kind`=0) puts request address bits 23:1 on `bus_addr_o` unchanged.
- R7: A programmed I/O cycle (`req_kind`=1) drives address bits 23:16 to 0 and passes bits 15:1.
- R8: A coprocessor command cycle (`req_kind`=2) drives byte address 8000F8h, whatever the request address is, and is always a word transfer.
- R9: A coprocessor data cycle (`req_kind`=3) drives 8000FCh when request bit 1 is 0 and 8000FEh when it is 1. It is always a word transfer.
- R10: A word request with an odd address on a memory or I/O cycle sets `req_err_o` for that internal clock and starts no cycle. In that case `cyc_active_o`=0, both enables are 1 and the address holds its previous value.
- R11: While `hold_ack` is 1, `addr_oe_o` and `data_oe_o` are both 0, in the same cycle. Otherwise `addr_oe_o` is 1.
- R12: `data_oe_o` is 1 only during an active write cycle outside hold.
- R13: After reset the address is 0, both enables are 1, and `cyc_active_o`, `req_err_o` and `data_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate clock, one period per internal phase |
| rst_n | input | 1 | Synchronous active-low reset, realigns the phase |
| req_valid | input | 1 | Request present at the phase-one boundary |
| req_addr | input | 24 | Byte address of the request |
| req_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| req_kind | input | 2 | 0 memory, 1 I/O, 2 coprocessor command, 3 coprocessor data |
| req_write | input | 1 | 1 = write, 0 = read |
| hold_ack | input | 1 | Bus hold acknowledged; pads must float |
| phase2_o | output | 1 | 0 in phase one, 1 in phase two |
| bus_addr_o | output | 23 | Word address lines 23:1 |
| ube_n_o | output | 1 | Upper lane enable (data 15:8), active low |
| lbe_n_o | output | 1 | Lower lane enable (data 7:0), active low |
| addr_oe_o | output | 1 | Drive enable for address and lane pads |
| data_oe_o | output | 1 | Drive enable for data pads |
| cyc_active_o | output | 1 | A bus cycle is in progress |
| req_err_o | output | 1 | Last request was a misaligned word and was refused |

## Verification
The bench builds the block with its default parameters: 24 address bits, a 16-bit I/O window and the fixed coprocessor addresses. With these values the full 16 Mbyte memory range is reachable, and so is the boundary where I/O addresses above 64 Kbytes must lose their upper bits. Every cycle kind is exercised with both sizes and all four combinations of address bits 1 and 0, and then with long pseudo-random streams that mix in hold. A reset is applied in mid-run at an odd phase to show that the phase realignment happens.

// File: rtl/bus_lane_pkg.sv
// Package: shared cycle-kind encoding for the bus address and lane generator.
// Assumes the 2-bit kind code fixed by the requirements (0..3).
package bus_lane_pkg;
    typedef enum logic [1:0] {
        KIND_MEM    = 2'd0,
        KIND_IO     = 2'd1,
        KIND_CPCMD  = 2'd2,
        KIND_CPDATA = 2'd3
    } cyc_kind_e;
endpackage

// File: rtl/bus_phase_track.sv
// Module: bus_phase_track
// Tracks the two-phase internal clock from the double-rate clock. Reset
// forces phase two, so the first edge after release opens phase one.
// Assumes rst_n is synchronous to clk2.
module bus_phase_track (
    input  logic clk2,
    input  logic rst_n,
    output logic ph2_q,
    output logic open_ph1
);
    // Purpose: toggle the phase each clk2 period, realign on reset.
    always_ff @(posedge clk2) begin
        if (!rst_n) ph2_q <= 1'b1;
        else        ph2_q <= ~ph2_q;
    end

    assign open_ph1 = rst_n & ph2_q;

    a_r1_phase_toggles: assert property (@(posedge clk2) disable iff (!rst_n)
        $past(rst_n) |-> (ph2_q != $past(ph2_q)));
endmodule

// File: rtl/bus_addr_map.sv
// Module: bus_addr_map
// Combinational decode of a request into pin address, lane enables and a
// misalignment flag. Coprocessor kinds substitute fixed addresses and are
// always word transfers. Assumes byte addressing with bit 0 as lane select.
module bus_addr_map
    import bus_lane_pkg::*;
#(
    parameter int          ADDR_W       = 24,
    parameter int          IO_W         = 16,
    parameter logic [23:0] CP_CMD_ADDR  = 24'h8000F8,
    parameter logic [23:0] CP_DATA_ADDR = 24'h8000FC
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  cyc_kind_e         req_kind,
    output logic [ADDR_W-1:1] map_addr,
    output logic              map_ube_n,
    output logic              map_lbe_n,
    output logic              misaligned
);
    localparam logic [ADDR_W-1:0] IO_MASK = (ADDR_W)'((64'd1 << IO_W) - 64'd1);
    localparam logic [ADDR_W-1:0] CP_DATA_ALT = CP_DATA_ADDR[ADDR_W-1:0] | (ADDR_W)'(2);

    logic [ADDR_W-1:0] byte_addr;
    logic              force_word;

    // Purpose: choose the byte address driven for each cycle kind.
    always_comb begin
        force_word = 1'b0;
        case (req_kind)
            KIND_MEM:   byte_addr = req_addr;
            KIND_IO:    byte_addr = req_addr & IO_MASK;
            KIND_CPCMD: begin
                byte_addr  = CP_CMD_ADDR[ADDR_W-1:0];
                force_word = 1'b1;
            end
            default: begin
                byte_addr  = req_addr[1] ? CP_DATA_ALT : CP_DATA_ADDR[ADDR_W-1:0];
                force_word = 1'b1;
            end
        endcase
    end

    // Purpose: derive active-low lane enables and the misalignment flag.
    always_comb begin
        map_addr   = byte_addr[ADDR_W-1:1];
        misaligned = req_word & req_addr[0] & ~force_word;
        if (req_word | force_word) begin
            map_ube_n = 1'b0;
            map_lbe_n = 1'b0;
        end else begin
            map_ube_n = ~req_addr[0];
            map_lbe_n = req_addr[0];
        end
    end
endmodule

// File: rtl/bus_cycle_reg.sv
// Module: bus_cycle_reg
// Registers a decoded request at each edge that opens phase one and holds
// it for the internal clock. Refuses misaligned requests with an error flag.
// Assumes 'load' is high for exactly one clk2 edge per internal clock.
module bus_cycle_reg
    import bus_lane_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16
) (
    input  logic              clk2,
    input  logic              rst_n,
    input  logic              load,
    input  logic              req_valid,
    input  logic              req_write,
    input  cyc_kind_e         req_kind,
    input  logic [ADDR_W-1:1] map_addr,
    input  logic              map_ube_n,
    input  logic              map_lbe_n,
    input  logic              misaligned,
    output logic [ADDR_W-1:1] addr_q,
    output logic              ube_n_q,
    output logic              lbe_n_q,
    output logic              active_q,
    output logic              write_q,
    output logic              err_q
);
    cyc_kind_e kind_q;

    // Purpose: capture a new bus cycle or idle at each phase-one boundary.
    always_ff @(posedge clk2) begin
        if (!rst_n) begin
            addr_q   <= '0;
            ube_n_q  <= 1'b1;
            lbe_n_q  <= 1'b1;
            active_q <= 1'b0;
            write_q  <= 1'b0;
            err_q    <= 1'b0;
            kind_q   <= KIND_MEM;
        end else if (load) begin
            if (req_valid && !misaligned) begin
                addr_q   <= map_addr;
                ube_n_q  <= map_ube_n;
                lbe_n_q  <= map_lbe_n;
                active_q <= 1'b1;
                write_q  <= req_write;
                err_q    <= 1'b0;
                kind_q   <= req_kind;
            end else begin
                ube_n_q  <= 1'b1;
                lbe_n_q  <= 1'b1;
                active_q <= 1'b0;
                write_q  <= 1'b0;
                err_q    <= req_valid;
            end
        end
    end

    a_r2_hold_between: assert property (@(posedge clk2) disable iff (!rst_n)
        !$past(load) |-> ($stable(addr_q) && $stable(ube_n_q) && $stable(lbe_n_q)
                          && $stable(active_q) && $stable(err_q)));
    a_r5_no_idle_lanes: assert property (@(posedge clk2) disable iff (!rst_n)
        active_q |-> !(ube_n_q && lbe_n_q));
    a_r7_io_upper_low: assert property (@(posedge clk2) disable iff (!rst_n)
        (active_q && kind_q == KIND_IO) |-> (addr_q[ADDR_W-1:IO_W] == '0));
    a_r8_cop_fixed: assert property (@(posedge clk2) disable iff (!rst_n)
        (active_q && (kind_q == KIND_CPCMD || kind_q == KIND_CPDATA)) |->
        (addr_q[ADDR_W-1] && !ube_n_q && !lbe_n_q));
    a_r10_err_no_cycle: assert property (@(posedge clk2) disable iff (!rst_n)
        err_q |-> (!active_q && ube_n_q && lbe_n_q));
endmodule

// File: rtl/bus_lane_gen.sv
// Module: bus_lane_gen (top)
// Turns transfer requests into word address, byte-lane enables and pad
// drive enables for a 16-bit bus; floats the pads during bus hold.
// Assumes all inputs synchronous to clk2 and reset synchronous active low.
module bus_lane_gen
    import bus_lane_pkg::*;
#(
    parameter int          ADDR_W       = 24,
    parameter int          IO_W         = 16,
    parameter logic [23:0] CP_CMD_ADDR  = 24'h8000F8,
    parameter logic [23:0] CP_DATA_ADDR = 24'h8000FC
) (
    input  logic              clk2,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic              hold_ack,
    output logic              phase2_o,
    output logic [ADDR_W-1:1] bus_addr_o,
    output logic              ube_n_o,
    output logic              lbe_n_o,
    output logic              addr_oe_o,
    output logic              data_oe_o,
    output logic              cyc_active_o,
    output logic              req_err_o
);
    logic              open_ph1;
    logic [ADDR_W-1:1] map_addr;
    logic              map_ube_n, map_lbe_n, misaligned;
    logic              write_q;
    cyc_kind_e         kind_in;

    assign kind_in = cyc_kind_e'(req_kind);

    bus_phase_track u_phase (
        .clk2     (clk2),
        .rst_n    (rst_n),
        .ph2_q    (phase2_o),
        .open_ph1 (open_ph1)
    );

    bus_addr_map #(
        .ADDR_W       (ADDR_W),
        .IO_W         (IO_W),
        .CP_CMD_ADDR  (CP_CMD_ADDR),
        .CP_DATA_ADDR (CP_DATA_ADDR)
    ) u_map (
        .req_addr   (req_addr),
        .req_word   (req_word),
        .req_kind   (kind_in),
        .map_addr   (map_addr),
        .map_ube_n  (map_ube_n),
        .map_lbe_n  (map_lbe_n),
        .misaligned (misaligned)
    );

    bus_cycle_reg #(
        .ADDR_W (ADDR_W),
        .IO_W   (IO_W)
    ) u_cyc (
        .clk2       (clk2),
        .rst_n      (rst_n),
        .load       (open_ph1),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_kind   (kind_in),
        .map_addr   (map_addr),
        .map_ube_n  (map_ube_n),
        .map_lbe_n  (map_lbe_n),
        .misaligned (misaligned),
        .addr_q     (bus_addr_o),
        .ube_n_q    (ube_n_o),
        .lbe_n_q    (lbe_n_o),
        .active_q   (cyc_active_o),
        .write_q    (write_q),
        .err_q      (req_err_o)
    );

    // Purpose: release the pads while hold is acknowledged.
    always_comb begin
        addr_oe_o = ~hold_ack;
        data_oe_o = ~hold_ack & cyc_active_o & write_q;
    end

    a_r12_data_only_write: assert property (@(posedge clk2) disable iff (!rst_n)
        data_oe_o |-> (cyc_active_o && !ube_n_o || cyc_active_o && !lbe_n_o));
endmodule

// File: tb/bus_lane_gen_bench.sv
// Bench: behavioural reference model updated on every clk2 edge, compared
// with the design outputs on every falling edge.
module bus_lane_gen_bench;
    logic        clk2 = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic        hold_ack = 1'b0;
    logic        phase2_o;
    logic [23:1] bus_addr_o;
    logic        ube_n_o, lbe_n_o, addr_oe_o, data_oe_o, cyc_active_o, req_err_o;

    int checks = 0;
    int errors = 0;

    always #5 clk2 = ~clk2;

    bus_lane_gen u_bus_lane_gen (
        .clk2(clk2), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_kind(req_kind), .req_write(req_write),
        .hold_ack(hold_ack), .phase2_o(phase2_o), .bus_addr_o(bus_addr_o),
        .ube_n_o(ube_n_o), .lbe_n_o(lbe_n_o), .addr_oe_o(addr_oe_o),
        .data_oe_o(data_oe_o), .cyc_active_o(cyc_active_o), .req_err_o(req_err_o)
    );

    // Reference model state
    int          m_ph2 = 1;
    logic [23:0] m_addr = '0;
    int          m_ube = 1, m_lbe = 1, m_act = 0, m_err = 0, m_wr = 0, m_kind = 0;

    always @(posedge clk2) begin
        if (!rst_n) begin
            m_ph2 = 1; m_addr = '0; m_ube = 1; m_lbe = 1;
            m_act = 0; m_err = 0; m_wr = 0; m_kind = 0;
        end else begin
            if (m_ph2 == 1) begin
                if (req_valid && req_word && req_addr[0] && req_kind < 2) begin
                    m_act = 0; m_err = 1; m_ube = 1; m_lbe = 1; m_wr = 0;
                end else if (req_valid) begin
                    m_act = 1; m_err = 0; m_wr = req_write; m_kind = req_kind;
                    case (req_kind)
                        0: m_addr = {req_addr[23:1], 1'b0};
                        1: m_addr = {8'h00, req_addr[15:1], 1'b0};
                        2: m_addr = 24'h8000F8;
                        default: m_addr = req_addr[1] ? 24'h8000FE : 24'h8000FC;
                    endcase
                    if (req_word || req_kind >= 2) begin m_ube = 0; m_lbe = 0; end
                    else if (req_addr[0]) begin m_ube = 0; m_lbe = 1; end
                    else begin m_ube = 1; m_lbe = 0; end
                end else begin
                    m_act = 0; m_err = 0; m_ube = 1; m_lbe = 1; m_wr = 0;
                end
            end
            m_ph2 = 1 - m_ph2;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [23:0] a_full;
        string atag;
        a_full = {bus_addr_o, 1'b0};
        check(phase2_o == m_ph2[0], "R1 phase", 32'(phase2_o), 32'(m_ph2));
        if (m_ph2 == 1) atag = "R2 held address";
        else if (m_kind == 0) atag = "R6 memory address";
        else if (m_kind == 1) atag = "R7 io address";
        else if (m_kind == 2) atag = "R8 cop command address";
        else atag = "R9 cop data address";
        check(a_full == m_addr, atag, 32'(a_full), 32'(m_addr));
        check(ube_n_o == m_ube[0] && lbe_n_o == m_lbe[0],
              m_act != 0 ? "R3 R4 lane enables" : "R5 idle lanes",
              {30'd0, ube_n_o, lbe_n_o}, 32'(m_ube * 2 + m_lbe));
        check(!(cyc_active_o && ube_n_o && lbe_n_o), "R5 both high in cycle",
              {30'd0, ube_n_o, lbe_n_o}, 32'd0);
        check(cyc_active_o == m_act[0] && req_err_o == m_err[0], "R10 active/error",
              {30'd0, cyc_active_o, req_err_o}, 32'(m_act * 2 + m_err));
        check(addr_oe_o == !hold_ack, "R11 address pad enable", 32'(addr_oe_o), 32'(!hold_ack));
        check(data_oe_o == (m_act != 0 && m_wr != 0 && !hold_ack), "R12 data pad enable",
              32'(data_oe_o), 32'(m_act != 0 && m_wr != 0 && !hold_ack));
    endtask

    task automatic drive(input bit v, input logic [23:0] a, input bit w,
                         input logic [1:0] k, input bit wr, input bit h);
        req_valid = v; req_addr = a; req_word = w; req_kind = k;
        req_write = wr; hold_ack = h;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk2);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [31:0] lfsr = 32'h1ACE_B00C;

    initial begin
        repeat (3) @(posedge clk2);
        @(negedge clk2);
        // R13: reset state
        check(bus_addr_o == '0 && ube_n_o && lbe_n_o && !cyc_active_o && !req_err_o
              && !data_oe_o, "R13 reset state",
              {bus_addr_o, 1'b0, ube_n_o, lbe_n_o}, 32'h3);
        check(phase2_o == 1'b1, "R1 reset phase", 32'(phase2_o), 32'd1);
        rst_n = 1'b1;
        // directed sweep: every kind, size and low address pattern
        for (int k = 0; k < 4; k++)
            for (int w = 0; w < 2; w++)
                for (int lo = 0; lo < 4; lo++)
                    for (int h = 0; h < 2; h++) begin
                        drive(1'b1, 24'hC5A3C0 | 24'(lo), w[0], k[1:0], lo[0], h[0]);
                        repeat (2) begin
                            @(negedge clk2);
                            compare_all();
                        end
                    end
        // idle gap
        drive(1'b0, '0, 1'b0, 2'd0, 1'b0, 1'b0);
        repeat (4) begin @(negedge clk2); compare_all(); end
        // pseudo-random stream with hold and a mid-run reset at an odd phase
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr[0] | lfsr[1], lfsr[31:8], lfsr[2], lfsr[4:3], lfsr[5],
                  lfsr[7:6] == 2'b11);
            rst_n = !(i >= 3001 && i <= 3003);
            @(negedge clk2);
            compare_all();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule